// File: doc/BRIEF.md
# Motor Lock Supervisor

This block watches a brushless motor drive during startup. While the motor runs in its low-speed block-commutation mode, it counts ticks from a slow time-base oscillator. If the commutation logic does not report the switch to sinusoidal drive before a full detection period has elapsed, the motor is treated as stalled. The block then withdraws the drive enable and raises a lock status flag.

What happens after a lock depends on a restart-mode input, which is sampled at the moment the lock is declared. In automatic mode the outputs stay off for one period of the same length and are then enabled again for a fresh detection period. This on/off cycle repeats until the motor reaches sinusoidal mode. In latched mode the outputs stay off until the supply-low monitor or the speed-command-low flag is asserted, which stands for a power cycle or the speed command being taken to zero.

The detection period and the off period are both 2^CNT_W ticks of the time base. With the default width of 10 bits and a 2 kHz tick this is about half a second.

Top module: `motor_lock_guard`

## Requirements
- R1: After reset, `lock_flag` is 0, the tick counter is 0, and `drv_en` is 1 when `supply_low` and `speed_low` are both 0.
- R2: With `sine_mode`, `speed_low` and `supply_low` all held at 0, `lock_flag` rises and `drv_en` falls on the clock edge that samples the 1024th (2^CNT_W) tick. After 1023 ticks the block is still unlocked.
- R3: Only clock cycles in which `tick` is 1 advance the detection or off-period count. Cycles with `tick` at 0 have no effect, however many there are.
- R4: A cycle with `sine_mode` at 1 while unlocked clears the detection count. A full 1024 further ticks are then needed for a lock.
- R5: When `auto_restart` is 1 at the lock edge, the outputs stay off for exactly 1024 ticks. `lock_flag` then falls, `drv_en` returns to 1 and a new detection period starts, so the on/off cycle repeats.
- R6: During an automatic off period, `sine_mode` at 1 clears the lock on the next clock edge.
- R7: When `auto_restart` is 0 at the lock edge, the lock holds for any number of ticks. It clears on the first clock edge that samples `speed_low` or `supply_low` at 1.
- R8: `drv_en` is 0 in every cycle in which `supply_low` or `speed_low` is 1.
- R9: A cycle with `supply_low` or `speed_low` at 1 clears the detection count. No detection ticks are counted while either flag is 1.
- R10: Changing `auto_restart` while a latched lock is held has no effect: the lock stays set.
- R11: `drv_en` equals NOT `lock_flag` whenever `supply_low` and `speed_low` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the slow time base |
| sine_mode | input | 1 | High once the drive has entered sinusoidal mode |
| auto_restart | input | 1 | 1 = periodic automatic restart, 0 = latched until power or speed cycle |
| speed_low | input | 1 | Speed command is below its run threshold |
| supply_low | input | 1 | Undervoltage monitor reports the supply below its threshold |
| drv_en | output | 1 | Enable for the power stage |
| lock_flag | output | 1 | High while this block holds the outputs off |

## Verification
The assertions assume that `tick` is a synchronous single-cycle pulse. They also assume that the flag inputs change only between clock edges and are free of glitches; the hysteresis on the supply flag is applied before it reaches this block. The bench drives every input on the falling clock edge and makes each tick exactly one cycle wide with at least one idle cycle after it. The mode select is changed only while a lock is held or before a test starts. The bench also holds the stop flags for long tick runs, to show that counting is suppressed at the ports rather than only reset.

// File: rtl/mlg_pkg.sv
package mlg_pkg;

   typedef enum logic [1:0] {
      ST_WATCH = 2'd0,
      ST_REST  = 2'd1,
      ST_HELD  = 2'd2
   } guard_state_t;

   function automatic logic is_locked(input guard_state_t s);
      return s != ST_WATCH;
   endfunction

endpackage

// File: rtl/mlg_period_counter.sv
module mlg_period_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [CNT_W-1:0] count,
   output logic             done
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   initial begin
      if (CNT_W < 2 || CNT_W > 24)
         $error("mlg_period_counter: CNT_W must be in 2..24");
   end

   assign done = adv && !clr && (count == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (adv)
         count <= count + 1'b1;
   end

   // R3
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(count));

   // R4
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

endmodule

// File: rtl/mlg_lock_fsm.sv
module mlg_lock_fsm
   import mlg_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         run_sine,
   input  logic         stop_req,
   input  logic         auto_mode,
   input  logic         period_done,
   output guard_state_t state,
   output logic         cnt_clr,
   output logic         cnt_adv
);
   guard_state_t state_nx;

   always_comb begin
      state_nx = state;
      cnt_clr  = 1'b0;
      cnt_adv  = 1'b0;
      unique case (state)
         ST_WATCH: begin
            if (stop_req || run_sine) begin
               cnt_clr = 1'b1;
            end else begin
               cnt_adv = tick;
               if (period_done)
                  state_nx = auto_mode ? ST_REST : ST_HELD;
            end
         end
         ST_REST: begin
            if (stop_req || run_sine) begin
               cnt_clr  = 1'b1;
               state_nx = ST_WATCH;
            end else begin
               cnt_adv = tick;
               if (period_done)
                  state_nx = ST_WATCH;
            end
         end
         ST_HELD: begin
            cnt_clr = 1'b1;
            if (stop_req)
               state_nx = ST_WATCH;
         end
         default: begin
            cnt_clr  = 1'b1;
            state_nx = ST_WATCH;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_WATCH;
      else
         state <= state_nx;
   end

   // R7
   held_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HELD && !stop_req) |=> (state == ST_HELD));

   // R2
   lock_needs_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WATCH && !period_done) |=> (state == ST_WATCH));

   // R6
   sine_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REST && run_sine) |=> (state == ST_WATCH));

endmodule

// File: rtl/motor_lock_guard.sv
module motor_lock_guard
   import mlg_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sine_mode,
   input  logic auto_restart,
   input  logic speed_low,
   input  logic supply_low,
   output logic drv_en,
   output logic lock_flag
);
   logic             stop_req;
   logic             cnt_clr;
   logic             cnt_adv;
   logic             period_done;
   logic [CNT_W-1:0] count;
   guard_state_t     state;
   logic             en_raw;
   logic             lock_raw;

   assign stop_req = speed_low || supply_low;

   mlg_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .adv   (cnt_adv),
      .count (count),
      .done  (period_done)
   );

   mlg_lock_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .run_sine    (sine_mode),
      .stop_req    (stop_req),
      .auto_mode   (auto_restart),
      .period_done (period_done),
      .state       (state),
      .cnt_clr     (cnt_clr),
      .cnt_adv     (cnt_adv)
   );

   assign lock_raw = is_locked(state);
   assign en_raw   = !lock_raw && !stop_req;

   generate
      if (OUT_REG) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               drv_en    <= 1'b0;
               lock_flag <= 1'b0;
            end else begin
               drv_en    <= en_raw;
               lock_flag <= lock_raw;
            end
         end
      end else begin : g_comb_out
         assign drv_en    = en_raw;
         assign lock_flag = lock_raw;

         // R8
         stop_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stop_req |-> !drv_en);

         // R9
         stop_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_req && !lock_flag) |=> (count == '0));
      end
   endgenerate

   // R11
   no_drive_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lock_flag && drv_en));

   // R4
   sine_zeroes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sine_mode && state == ST_WATCH) |=> (count == '0));

endmodule

// File: tb/sim_motor_lock_guard.sv
`timescale 1ns/1ps
module sim_motor_lock_guard;
   localparam int PER = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, sine_mode = 1'b0, auto_restart = 1'b0;
   logic speed_low = 1'b0, supply_low = 1'b0;
   logic drv_en, lock_flag;
   int   n_chk = 0, n_err = 0;
   int   cyc = 0;
   bit   done_flag = 1'b0;

   always #4 clk = ~clk;

   motor_lock_guard u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sine_mode(sine_mode),
      .auto_restart(auto_restart), .speed_low(speed_low),
      .supply_low(supply_low), .drv_en(drv_en), .lock_flag(lock_flag)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done_flag) begin
         done_flag = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; sine_mode = 1'b0; speed_low = 1'b0; supply_low = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic pulse_one(ref logic sig);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   task automatic t_reset();
      auto_restart = 1'b0;
      do_reset();
      check("R1 lock_flag after reset", lock_flag, 1'b0);
      check("R1 drv_en after reset", drv_en, 1'b1);
   endtask

   task automatic t_lock_edge();
      auto_restart = 1'b0;
      do_reset();
      send_ticks(PER - 1);
      check("R2 no lock after 1023 ticks", lock_flag, 1'b0);
      repeat (60) @(negedge clk);
      check("R3 idle cycles do not count", lock_flag, 1'b0);
      send_ticks(1);
      check("R2 lock on 1024th tick", lock_flag, 1'b1);
      check("R11 drv_en off when locked", drv_en, 1'b0);
   endtask

   task automatic t_sine_clear();
      auto_restart = 1'b0;
      do_reset();
      send_ticks(600);
      pulse_one(sine_mode);
      @(negedge clk);
      send_ticks(PER - 1);
      check("R4 sine pulse restarted count", lock_flag, 1'b0);
      check("R11 drv_en while unlocked", drv_en, 1'b1);
      send_ticks(1);
      check("R4 lock after full period post-clear", lock_flag, 1'b1);
   endtask

   task automatic t_latched();
      auto_restart = 1'b0;
      do_reset();
      send_ticks(PER);
      check("R7 latched lock set", lock_flag, 1'b1);
      send_ticks(3000);
      check("R7 latched lock holds", lock_flag, 1'b1);
      auto_restart = 1'b1;
      send_ticks(PER + 50);
      check("R10 mode change ignored while latched", lock_flag, 1'b1);
      check("R10 drv_en stays off", drv_en, 1'b0);
      auto_restart = 1'b0;
      speed_low = 1'b1;
      @(negedge clk);
      check("R7 speed_low clears lock", lock_flag, 1'b0);
      check("R8 drv_en off while speed_low", drv_en, 1'b0);
      speed_low = 1'b0;
      @(negedge clk);
      check("R7 drive back after speed cycle", drv_en, 1'b1);
      send_ticks(PER);
      check("R7 relock", lock_flag, 1'b1);
      supply_low = 1'b1;
      @(negedge clk);
      check("R7 supply_low clears lock", lock_flag, 1'b0);
      check("R8 drv_en off while supply_low", drv_en, 1'b0);
      supply_low = 1'b0;
      @(negedge clk);
      check("R11 drv_en after supply cycle", drv_en, 1'b1);
   endtask

   task automatic t_auto();
      auto_restart = 1'b1;
      do_reset();
      send_ticks(PER);
      check("R5 auto lock set", lock_flag, 1'b1);
      send_ticks(PER - 1);
      check("R5 still off after 1023 ticks", lock_flag, 1'b1);
      check("R5 drv_en off during rest", drv_en, 1'b0);
      send_ticks(1);
      check("R5 lock released after 1024 ticks", lock_flag, 1'b0);
      check("R5 drv_en restored", drv_en, 1'b1);
      send_ticks(PER - 1);
      check("R5 new detection period not yet done", lock_flag, 1'b0);
      send_ticks(1);
      check("R5 relock on second period", lock_flag, 1'b1);
   endtask

   task automatic t_auto_sine();
      auto_restart = 1'b1;
      do_reset();
      send_ticks(PER);
      send_ticks(100);
      check("R6 locked before sine", lock_flag, 1'b1);
      sine_mode = 1'b1;
      @(negedge clk);
      check("R6 sine clears rest period", lock_flag, 1'b0);
      check("R6 drv_en back on", drv_en, 1'b1);
      send_ticks(PER + 10);
      check("R4 no lock while sine held", lock_flag, 1'b0);
      sine_mode = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_stop_clears();
      auto_restart = 1'b0;
      do_reset();
      send_ticks(800);
      pulse_one(supply_low);
      @(negedge clk);
      send_ticks(PER - 1);
      check("R9 supply pulse restarted count", lock_flag, 1'b0);
      speed_low = 1'b1;
      send_ticks(2 * PER);
      check("R9 no counting while speed_low", lock_flag, 1'b0);
      check("R8 drv_en off while speed_low held", drv_en, 1'b0);
      speed_low = 1'b0;
      @(negedge clk);
      send_ticks(PER - 1);
      check("R9 count started from zero", lock_flag, 1'b0);
      send_ticks(1);
      check("R9 lock after full period", lock_flag, 1'b1);
   endtask

   initial begin
      t_reset();
      t_lock_edge();
      t_sine_clear();
      t_latched();
      t_auto();
      t_auto_sine();
      t_stop_clears();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule